// File: doc/BRIEF.md
# Host Register and Interrupt Interface

This block sits between a host processor and a serial bus controller. It exposes a small byte-addressed register space. Through it the host sets the controller's configuration: the link mode and option bits, timing lengths, baud dividers, the local address and the interrupt mask. The host also reads back a 16-bit status word that the receiver and transmitter keep current. A single interrupt line is raised whenever a status bit is set whose mask bit is also set.

Registers wider than one byte sit at two consecutive addresses, with the high byte at the lower address. The host writes the high byte first and the low byte last. Only the low-byte write changes the register, and the high byte may be skipped when it is zero. Five of the error and event status bits are sticky and clear when the host reads the low status byte. A read may also continue from the previous read address without the host sending a new address. Starting at the low status byte, three such reads return status-low, receive length and status-high.

Top module: `hostreg_ctl`

Address map: 0x00 identity (read only), 0x01 settings, 0x02 idle wait, 0x03 local address, 0x04/0x05 transmit permit (high/low), 0x06/0x07 maximum idle, 0x08/0x09 slow divider, 0x0A/0x0B fast divider, 0x0C/0x0D interrupt mask, 0x10 status low, 0x11 receive length, 0x12 status high (these three are read only).

## Requirements
- R1: After reset: settings 0x10, idle wait 0x0A, local address 0xFF, transmit permit 0x014, maximum idle 0x0C8, both dividers 0x015A, interrupt mask 0x0000. The identity address reads the parameter ID_VALUE (default 0x21).
- R2: A write to the high address of a wide register, followed by a write to its low address, loads {high, low}. The new value appears on the configuration output and in read-back from the cycle after the low-byte write.
- R3: A low-byte write that no high-byte write has preceded since the last low-byte write loads a high byte of zero. The staged high byte is therefore dropped at every low-byte commit, and one staging byte is shared by all wide registers.
- R4: A high-byte write on its own leaves the register's output and read-back unchanged.
- R5: Transmit permit and maximum idle keep only their PERMIT_W and MAXIDLE_W low bits (10 by default). Bits above these read as zero.
- R6: The status word, with the low byte at 0x10 and the high byte at 0x12, is: bit15 bus busy, bit14 bus idle, bits13:8 pending receive pages, bit7 transmit error, bit6 collision, bit5 transmit page released, bit4 empty transmit page, bit3 receive broken, bit2 receive lost, bit1 break received, bit0 receive page ready.
- R7: irq is high exactly when the status word ANDed with the interrupt mask is nonzero.
- R8: A read of 0x10 clears the sticky bits 7, 6, 3, 2 and 1 from the next cycle. Reads of other addresses clear nothing.
- R9: An event pulse in the same cycle as a clearing read leaves its bit set after that read.
- R10: With settings bit3 set, status bit3 follows the current-page-broken input, and reads do not clear it.
- R11: A read with host_rd_next high ignores host_addr and uses the previous read address plus one. From 0x10, two continued reads return the receive length and then the high status byte.
- R12: Settings bits 5:4 drive cfg_mode: 00 half-duplex, 01 arbitration, 10 break-sync, 11 full-duplex.
- R13: Writes to read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_rd_next | input | 1 | Continue at previous read address plus one |
| host_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| ev_tx_err | input | 1 | Pulse: transmit error |
| ev_collision | input | 1 | Pulse: collision |
| ev_rx_broken | input | 1 | Pulse: broken frame received |
| ev_rx_lost | input | 1 | Pulse: frame lost, no free page |
| ev_break | input | 1 | Pulse: break received |
| st_bus_idle | input | 1 | Level: bus idle |
| st_rx_pend | input | 6 | Level: pending receive pages |
| st_tx_released | input | 1 | Level: transmit page released |
| st_tx_empty | input | 1 | Level: empty transmit page exists |
| st_rx_ready | input | 1 | Level: receive page ready |
| st_page_broken | input | 1 | Level: page being read is broken |
| st_rx_len | input | 8 | Length of the frame to be read |
| cfg_setting | output | 8 | Settings byte |
| cfg_mode | output | 2 | Link mode field |
| cfg_idle_wait | output | 8 | Idle wait length |
| cfg_local_addr | output | 8 | Local address |
| cfg_tx_permit | output | PERMIT_W | Transmit permit length |
| cfg_max_idle | output | MAXIDLE_W | Maximum idle length |
| cfg_div_slow | output | 16 | Slow-phase divider |
| cfg_div_fast | output | 16 | Fast-phase divider |
| cfg_int_mask | output | 16 | Interrupt mask |

## Verification
Two functions can fall in the same cycle: the host reading the low status byte, which clears the sticky bits, and an event pulse from the controller, which sets one. The bench drives a collision pulse in the very cycle of a status-low read. It checks that the data read in that cycle still shows the bit clear, and that the next read shows the bit set. A continued burst read is also issued from the status-low address, so the clear and the address step happen together. The bench then checks that the three bytes arrive in order.

// File: rtl/hostreg_pkg.sv
// Shared constants, types and helpers for the host register interface.
// Assumes an 8-bit data path and at most 256 register addresses.
package hostreg_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NUM_WIDE = 5;
    localparam int unsigned PEND_W   = 6;

    localparam logic [7:0] A_ID         = 8'h00;
    localparam logic [7:0] A_SETTING    = 8'h01;
    localparam logic [7:0] A_IDLE_WAIT  = 8'h02;
    localparam logic [7:0] A_LOCAL_ADDR = 8'h03;
    localparam logic [7:0] A_WIDE_BASE  = 8'h04;
    localparam logic [7:0] A_FLAG_LO    = 8'h10;
    localparam logic [7:0] A_RX_LEN     = 8'h11;
    localparam logic [7:0] A_FLAG_HI    = 8'h12;

    localparam logic [7:0] SETTING_RST  = 8'h10;
    localparam logic [7:0] IDLE_RST     = 8'h0a;
    localparam logic [7:0] LOCAL_RST    = 8'hff;
    localparam int unsigned SAVE_BROKEN_BIT = 3;

    typedef enum logic [1:0] {
        MODE_HALF    = 2'b00,
        MODE_ARB     = 2'b01,
        MODE_BRKSYNC = 2'b10,
        MODE_FULL    = 2'b11
    } link_mode_e;

    // Sticky event group, one bit per pulse source.
    typedef struct packed {
        logic tx_err;
        logic collision;
        logic rx_broken;
        logic rx_lost;
        logic brk_rx;
    } evt_t;

    function automatic logic [7:0] wide_hi_addr(input int idx);
        return A_WIDE_BASE + 8'(2 * idx);
    endfunction

    function automatic logic [7:0] wide_lo_addr(input int idx);
        return A_WIDE_BASE + 8'(2 * idx + 1);
    endfunction

    // Reset value per wide register: permit, max idle, slow div, fast div, mask.
    function automatic logic [15:0] wide_reset(input int idx);
        case (idx)
            0:       return 16'h0014;
            1:       return 16'h00c8;
            2, 3:    return 16'h015a;
            default: return 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/hostreg_hi_stage.sv
// Holds the high byte of a wide-register write until a low-byte write uses it.
// Assumes at most one of wr_hi and wr_lo is active in a cycle (one address).
// A single staging byte serves every wide register.
module hostreg_hi_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hi,
    input  logic       wr_lo,
    input  logic [7:0] wdata,
    output logic [7:0] hi_byte
);
    logic [7:0] stage_q;
    logic       valid_q;

    // Capture a high byte; a low-byte commit consumes and drops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            valid_q <= 1'b0;
        end else if (wr_hi) begin
            stage_q <= wdata;
            valid_q <= 1'b1;
        end else if (wr_lo) begin
            valid_q <= 1'b0;
        end
    end

    // An empty stage offers zero as the high byte.
    always_comb hi_byte = valid_q ? stage_q : 8'h00;

    p_stage_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (hi_byte == 8'h00))
        else $error("staged high byte survived a low-byte commit");
endmodule

// File: rtl/hostreg_wide_reg.sv
// One 16-bit configuration register, updated atomically on a low-byte commit.
// Assumes the high byte comes from the shared staging byte. Only KEEP_W low bits are stored.
module hostreg_wide_reg #(
    parameter logic [15:0] RST_VAL = 16'h0000,
    parameter int unsigned KEEP_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  logic [7:0]  hi,
    input  logic [7:0]  lo,
    output logic [15:0] q
);
    localparam logic [15:0] KEEP_MASK =
        (KEEP_W >= 16) ? 16'hffff : 16'((17'd1 << KEEP_W) - 17'd1);

    // Load both bytes in one edge so the consumer never sees half a value.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST_VAL & KEEP_MASK;
        else if (commit) q <= {hi, lo} & KEEP_MASK;
    end

    p_hold_until_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(q))
        else $error("wide register changed without a low-byte commit");
endmodule

// File: rtl/hostreg_burst.sv
// Chooses the read address: the host address, or the previous read address
// plus one when a read continues a burst. Assumes reads last one cycle.
module hostreg_burst (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic       rd_next,
    input  logic [7:0] addr,
    output logic [7:0] eff_addr
);
    logic [7:0] ptr_q;

    // A continued read takes the stored pointer, a fresh one the host address.
    always_comb eff_addr = rd_next ? ptr_q : addr;

    // Each read moves the pointer to the address after the one just read.
    always_ff @(posedge clk) begin
        if (!rst_n)  ptr_q <= '0;
        else if (rd) ptr_q <= eff_addr + 8'd1;
    end

    p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(ptr_q))
        else $error("burst pointer moved without a read");
endmodule

// File: rtl/hostreg_flags.sv
// Builds the 16-bit status word from sticky event bits and live levels, and
// drives the interrupt line. Assumes event inputs are single-cycle pulses.
// An event in the same cycle as a clearing read wins over the clear.
module hostreg_flags
    import hostreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_broken,
    input  logic              rd_clear,
    input  evt_t              ev,
    input  logic              bus_idle,
    input  logic [PEND_W-1:0] rx_pend,
    input  logic              tx_released,
    input  logic              tx_empty,
    input  logic              rx_ready,
    input  logic              page_broken,
    input  logic [15:0]       int_mask,
    output logic [15:0]       flag_word,
    output logic              irq
);
    evt_t stk_q;
    evt_t stk_d;

    // Set on event, clear on a status-low read, event taking priority.
    always_comb begin
        stk_d = ev | (rd_clear ? '0 : stk_q);
        if (save_broken) stk_d.rx_broken = 1'b0;
    end

    // Register the sticky group.
    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    // Assemble the status word in its fixed bit layout.
    always_comb begin
        flag_word = {
            ~bus_idle, bus_idle, rx_pend,
            stk_q.tx_err, stk_q.collision, tx_released, tx_empty,
            (save_broken ? page_broken : stk_q.rx_broken),
            stk_q.rx_lost, stk_q.brk_rx, rx_ready
        };
    end

    // The interrupt line is the OR of masked status bits.
    always_comb irq = |(flag_word & int_mask);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && ev == '0) |=> (flag_word[7:6] == 2'b00 && flag_word[2:1] == 2'b00))
        else $error("sticky bits survived a clearing read");

    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev.collision |=> flag_word[6])
        else $error("collision event lost");

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == 16'h0000) |-> !irq)
        else $error("irq raised with an empty mask");
endmodule

// File: rtl/hostreg_ctl.sv
// Top of the host register interface. Decodes byte reads and writes, holds
// the byte-wide configuration registers, instantiates one wide register per
// 16-bit setting and routes status into the flag block.
// Assumes host_wr and host_rd are single-cycle strobes and never both high.
module hostreg_ctl
    import hostreg_pkg::*;
#(
    parameter logic [7:0]  ID_VALUE  = 8'h21,
    parameter int unsigned PERMIT_W  = 10,
    parameter int unsigned MAXIDLE_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           host_addr,
    input  logic                 host_wr,
    input  logic [7:0]           host_wdata,
    input  logic                 host_rd,
    input  logic                 host_rd_next,
    output logic [7:0]           host_rdata,
    output logic                 irq,
    input  logic                 ev_tx_err,
    input  logic                 ev_collision,
    input  logic                 ev_rx_broken,
    input  logic                 ev_rx_lost,
    input  logic                 ev_break,
    input  logic                 st_bus_idle,
    input  logic [5:0]           st_rx_pend,
    input  logic                 st_tx_released,
    input  logic                 st_tx_empty,
    input  logic                 st_rx_ready,
    input  logic                 st_page_broken,
    input  logic [7:0]           st_rx_len,
    output logic [7:0]           cfg_setting,
    output logic [1:0]           cfg_mode,
    output logic [7:0]           cfg_idle_wait,
    output logic [7:0]           cfg_local_addr,
    output logic [PERMIT_W-1:0]  cfg_tx_permit,
    output logic [MAXIDLE_W-1:0] cfg_max_idle,
    output logic [15:0]          cfg_div_slow,
    output logic [15:0]          cfg_div_fast,
    output logic [15:0]          cfg_int_mask
);
    function automatic int keep_of(input int idx);
        case (idx)
            0:       return PERMIT_W;
            1:       return MAXIDLE_W;
            default: return 16;
        endcase
    endfunction

    logic [7:0]    setting_q, idle_q, local_q;
    logic [7:0]    eff_addr;
    logic [7:0]    hi_byte;
    logic [15:0]   wide_q [NUM_WIDE];
    logic [NUM_WIDE-1:0] hi_hit, lo_hit;
    logic          wr_hi_any, wr_lo_any, rd_clear;
    logic [15:0]   flag_word;
    evt_t          ev;
    link_mode_e    mode;

    // Pack the event pulses into the sticky group type.
    always_comb ev = '{tx_err: ev_tx_err, collision: ev_collision,
                       rx_broken: ev_rx_broken, rx_lost: ev_rx_lost,
                       brk_rx: ev_break};

    hostreg_burst u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (host_rd),
        .rd_next  (host_rd_next),
        .addr     (host_addr),
        .eff_addr (eff_addr)
    );

    // Decode the high and low address of each wide register.
    for (genvar gi = 0; gi < NUM_WIDE; gi++) begin : g_wide_dec
        assign hi_hit[gi] = host_wr && (host_addr == wide_hi_addr(gi));
        assign lo_hit[gi] = host_wr && (host_addr == wide_lo_addr(gi));
    end

    always_comb wr_hi_any = |hi_hit;
    always_comb wr_lo_any = |lo_hit;

    hostreg_hi_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_hi_any),
        .wr_lo   (wr_lo_any),
        .wdata   (host_wdata),
        .hi_byte (hi_byte)
    );

    for (genvar gi = 0; gi < NUM_WIDE; gi++) begin : g_wide
        hostreg_wide_reg #(
            .RST_VAL (wide_reset(gi)),
            .KEEP_W  (keep_of(gi))
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .commit (lo_hit[gi]),
            .hi     (hi_byte),
            .lo     (host_wdata),
            .q      (wide_q[gi])
        );
    end

    // Byte-wide configuration registers; read-only addresses fall through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setting_q <= SETTING_RST;
            idle_q    <= IDLE_RST;
            local_q   <= LOCAL_RST;
        end else if (host_wr) begin
            case (host_addr)
                A_SETTING:    setting_q <= host_wdata;
                A_IDLE_WAIT:  idle_q    <= host_wdata;
                A_LOCAL_ADDR: local_q   <= host_wdata;
                default: ;
            endcase
        end
    end

    // Any read that lands on the status-low address clears the sticky bits.
    always_comb rd_clear = host_rd && (eff_addr == A_FLAG_LO);

    hostreg_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_broken (setting_q[SAVE_BROKEN_BIT]),
        .rd_clear    (rd_clear),
        .ev          (ev),
        .bus_idle    (st_bus_idle),
        .rx_pend     (st_rx_pend),
        .tx_released (st_tx_released),
        .tx_empty    (st_tx_empty),
        .rx_ready    (st_rx_ready),
        .page_broken (st_page_broken),
        .int_mask    (wide_q[4]),
        .flag_word   (flag_word),
        .irq         (irq)
    );

    // Read multiplexer on the effective address.
    always_comb begin
        host_rdata = 8'h00;
        case (eff_addr)
            A_ID:         host_rdata = ID_VALUE;
            A_SETTING:    host_rdata = setting_q;
            A_IDLE_WAIT:  host_rdata = idle_q;
            A_LOCAL_ADDR: host_rdata = local_q;
            A_FLAG_LO:    host_rdata = flag_word[7:0];
            A_RX_LEN:     host_rdata = st_rx_len;
            A_FLAG_HI:    host_rdata = flag_word[15:8];
            default: ;
        endcase
        for (int i = 0; i < NUM_WIDE; i++) begin
            if (eff_addr == wide_hi_addr(i)) host_rdata = wide_q[i][15:8];
            if (eff_addr == wide_lo_addr(i)) host_rdata = wide_q[i][7:0];
        end
    end

    // Drive the configuration outputs.
    always_comb mode = link_mode_e'(setting_q[5:4]);
    assign cfg_setting    = setting_q;
    assign cfg_mode       = mode;
    assign cfg_idle_wait  = idle_q;
    assign cfg_local_addr = local_q;
    assign cfg_tx_permit  = wide_q[0][PERMIT_W-1:0];
    assign cfg_max_idle   = wide_q[1][MAXIDLE_W-1:0];
    assign cfg_div_slow   = wide_q[2];
    assign cfg_div_fast   = wide_q[3];
    assign cfg_int_mask   = wide_q[4];

    p_readonly_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr >= A_FLAG_LO) |=> $stable(cfg_setting) && $stable(cfg_int_mask))
        else $error("write to a read-only address changed state");
endmodule

// File: tb/hostreg_ctl_tb.sv
`timescale 1ns/1ps
module hostreg_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_rd_next = 1'b0;
    logic [7:0] host_rdata;
    logic       irq;
    logic       ev_tx_err = 0, ev_collision = 0, ev_rx_broken = 0, ev_rx_lost = 0, ev_break = 0;
    logic       st_bus_idle = 1'b1;
    logic [5:0] st_rx_pend = '0;
    logic       st_tx_released = 0, st_tx_empty = 0, st_rx_ready = 0, st_page_broken = 0;
    logic [7:0] st_rx_len = '0;
    logic [7:0] cfg_setting, cfg_idle_wait, cfg_local_addr;
    logic [1:0] cfg_mode;
    logic [9:0] cfg_tx_permit, cfg_max_idle;
    logic [15:0] cfg_div_slow, cfg_div_fast, cfg_int_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hostreg_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rd_next(host_rd_next),
        .host_rdata(host_rdata), .irq(irq),
        .ev_tx_err(ev_tx_err), .ev_collision(ev_collision), .ev_rx_broken(ev_rx_broken),
        .ev_rx_lost(ev_rx_lost), .ev_break(ev_break),
        .st_bus_idle(st_bus_idle), .st_rx_pend(st_rx_pend), .st_tx_released(st_tx_released),
        .st_tx_empty(st_tx_empty), .st_rx_ready(st_rx_ready), .st_page_broken(st_page_broken),
        .st_rx_len(st_rx_len),
        .cfg_setting(cfg_setting), .cfg_mode(cfg_mode), .cfg_idle_wait(cfg_idle_wait),
        .cfg_local_addr(cfg_local_addr), .cfg_tx_permit(cfg_tx_permit),
        .cfg_max_idle(cfg_max_idle), .cfg_div_slow(cfg_div_slow),
        .cfg_div_fast(cfg_div_fast), .cfg_int_mask(cfg_int_mask)
    );

    // Vector: {req[3:0], op[1:0], addr, wdata, expected}; op 0 write, 1 read, 2 continued read.
    localparam int NVEC = 33;
    localparam logic [29:0] VEC [NVEC] = '{
        {4'd1, 2'd1, 8'h00, 8'h00, 8'h21},  // R1 identity
        {4'd1, 2'd1, 8'h01, 8'h00, 8'h10},  // R1 settings
        {4'd1, 2'd1, 8'h02, 8'h00, 8'h0a},  // R1
        {4'd1, 2'd1, 8'h03, 8'h00, 8'hff},  // R1
        {4'd1, 2'd1, 8'h04, 8'h00, 8'h00},  // R1 permit hi
        {4'd1, 2'd1, 8'h05, 8'h00, 8'h14},  // R1 permit lo
        {4'd1, 2'd1, 8'h06, 8'h00, 8'h00},  // R1
        {4'd1, 2'd1, 8'h07, 8'h00, 8'hc8},  // R1
        {4'd1, 2'd1, 8'h08, 8'h00, 8'h01},  // R1
        {4'd1, 2'd1, 8'h09, 8'h00, 8'h5a},  // R1
        {4'd1, 2'd1, 8'h0a, 8'h00, 8'h01},  // R1
        {4'd1, 2'd1, 8'h0b, 8'h00, 8'h5a},  // R1
        {4'd1, 2'd1, 8'h0c, 8'h00, 8'h00},  // R1 mask
        {4'd1, 2'd1, 8'h0d, 8'h00, 8'h00},  // R1
        {4'd4, 2'd0, 8'h08, 8'h12, 8'h00},  // R4 stage high
        {4'd4, 2'd1, 8'h08, 8'h00, 8'h01},  // R4 unchanged
        {4'd4, 2'd1, 8'h09, 8'h00, 8'h5a},  // R4 unchanged
        {4'd2, 2'd0, 8'h09, 8'h34, 8'h00},  // R2 commit
        {4'd2, 2'd1, 8'h08, 8'h00, 8'h12},  // R2
        {4'd11, 2'd2, 8'h00, 8'h00, 8'h34}, // R11 continued read to 0x09
        {4'd3, 2'd0, 8'h0b, 8'h77, 8'h00},  // R3 low only
        {4'd3, 2'd1, 8'h0a, 8'h00, 8'h00},  // R3
        {4'd3, 2'd1, 8'h0b, 8'h00, 8'h77},  // R3
        {4'd5, 2'd0, 8'h04, 8'hff, 8'h00},  // R5
        {4'd5, 2'd0, 8'h05, 8'hee, 8'h00},  // R5
        {4'd5, 2'd1, 8'h04, 8'h00, 8'h03},  // R5 truncated high
        {4'd5, 2'd1, 8'h05, 8'h00, 8'hee},  // R5
        {4'd3, 2'd0, 8'h05, 8'h11, 8'h00},  // R3 stale stage dropped
        {4'd3, 2'd1, 8'h04, 8'h00, 8'h00},  // R3
        {4'd13, 2'd0, 8'h11, 8'haa, 8'h00}, // R13 read-only write
        {4'd13, 2'd0, 8'h00, 8'h55, 8'h00}, // R13
        {4'd13, 2'd1, 8'h00, 8'h00, 8'h21}, // R13 identity intact
        {4'd12, 2'd0, 8'h01, 8'h20, 8'h00}  // R12 break-sync mode
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic nxt, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1; host_rd_next = nxt;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; host_rd_next = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] v);
        @(negedge clk);
        {ev_tx_err, ev_collision, ev_rx_broken, ev_rx_lost, ev_break} = v;
        @(negedge clk);
        {ev_tx_err, ev_collision, ev_rx_broken, ev_rx_lost, ev_break} = '0;
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        check("R1 setting", cfg_setting, 16'h10);
        check("R12 default mode", cfg_mode, 16'h1);
        check("R1 mask", cfg_int_mask, 16'h0);
        check("R1 max idle", cfg_max_idle, 16'h0c8);
        check("R7 irq at reset", irq, 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] rq; logic [1:0] op; logic [7:0] a, wd, ex;
            {rq, op, a, wd, ex} = VEC[i];
            if (op == 2'd0) wr(a, wd);
            else begin
                rd(a, op == 2'd2, d);
                check($sformatf("R%0d vector %0d", rq, i), d, ex);
            end
        end

        // R12, R2, R3, R5 at the configuration ports
        check("R12 break-sync", cfg_mode, 16'h2);
        check("R2 slow divider", cfg_div_slow, 16'h1234);
        check("R3 fast divider", cfg_div_fast, 16'h0077);
        check("R5 permit", cfg_tx_permit, 16'h011);
        wr(8'h01, 8'h30);
        check("R12 full-duplex", cfg_mode, 16'h3);
        wr(8'h01, 8'h00);
        check("R12 half-duplex", cfg_mode, 16'h0);
        wr(8'h01, 8'h10);

        // R6 layout and R11 burst from status low
        st_rx_ready = 1; st_tx_empty = 1; st_tx_released = 1;
        st_rx_pend = 6'h2a; st_bus_idle = 0; st_rx_len = 8'h5e;
        rd(8'h10, 1'b0, d); check("R6 status low", d, 16'h31);
        rd(8'h00, 1'b1, d); check("R11 burst length", d, 16'h5e);
        rd(8'h00, 1'b1, d); check("R6 R11 burst status high", d, 16'haa);

        // R7 interrupt masking
        #1 check("R7 masked off", irq, 16'h0);
        wr(8'h0d, 8'h01);
        #1 check("R7 ready unmasked", irq, 16'h1);
        wr(8'h0c, 8'h80); wr(8'h0d, 8'h00);
        #1 check("R7 busy unmasked", irq, 16'h1);
        st_bus_idle = 1; #1 check("R7 busy gone", irq, 16'h0);
        st_rx_ready = 0; st_tx_empty = 0; st_tx_released = 0; st_rx_pend = 0;
        wr(8'h0d, 8'h00);

        // R8 read-clear of sticky bits
        pulse(5'h1f);
        rd(8'h12, 1'b0, d); check("R8 high read", d, 16'h40);
        rd(8'h10, 1'b0, d); check("R8 sticky set", d, 16'hce);
        rd(8'h10, 1'b0, d); check("R8 cleared", d, 16'h00);

        // R9 event during a clearing read
        @(negedge clk);
        host_addr = 8'h10; host_rd = 1; ev_collision = 1;
        #1 check("R9 read in event cycle", host_rdata, 16'h00);
        @(negedge clk);
        host_rd = 0; ev_collision = 0;
        rd(8'h10, 1'b0, d); check("R9 event kept", d, 16'h40);

        // R10 save-broken mode
        wr(8'h01, 8'h18);
        st_page_broken = 1;
        rd(8'h10, 1'b0, d); check("R10 page broken", d, 16'h08);
        rd(8'h10, 1'b0, d); check("R10 not cleared", d, 16'h08);
        st_page_broken = 0;
        pulse(5'h04);
        rd(8'h10, 1'b0, d); check("R10 follows input", d, 16'h00);
        wr(8'h01, 8'h10);
        rd(8'h10, 1'b0, d); check("R10 no hidden sticky", d, 16'h00);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule